// File: doc/BRIEF.md
# Root Clock Generator with Fractional M/N Stage

This block derives one output clock enable from a set of source clock enables, all running on a single fast reference clock. The source is picked by a select field. The chosen enable stream then passes through a pre-divider that works in half steps. An optional fractional stage follows, producing M output pulses for every N pulses it receives. In that fractional mode, a duty output stays high for a programmable share of each output period.

Software writes a shadow configuration through a small register port. The shadow covers the configuration word, M, the inverted form of (N − M), and the inverted duty value. Software then sets an update request bit and polls it. The hardware copies the shadow into the running divider only at the end of an output period, so no short pulse is produced. It clears the request bit in that same clock edge.

Top module: `clk_root_gen`

## Requirements
- R1: After reset, every register reads 0. Both outputs are 0. The running configuration is source 0, pre-divider bypassed, fractional stage off.
- R2: The source select field is cfg[10:8]. Only enables of the selected source are counted. A select value at or above NSRC yields no enables.
- R3: The pre-divider field is cfg[4:0], call it h. With h = 0, every selected enable passes through. With h > 0, a counter adds 2 per selected enable. When the counter reaches h+1, one pulse is emitted and h+1 is subtracted. This gives a ratio of (h+1)/2, which is an integer when h is odd.
- R4: With the mode field cfg[13:12] equal to 2, the fractional stage is active. The decoded N is (~Nreg + M) mod 2^MND_W. Each pre-divider pulse adds M to an accumulator. When the sum reaches N, a pulse is emitted and N is subtracted. With any other mode value, pre-divider pulses pass straight through.
- R5: In fractional mode, duty_o is high while the accumulator is below D, where D = ~Dreg mod 2^MND_W. In any other mode, duty_o is 0.
- R6: Register M is at address 1, N at address 2 and D at address 3. Each keeps only its low MND_W bits; the bits above read 0.
- R7: The configuration register is at address 0. It stores the fields [4:0], [10:8] and [13:12], plus a hardware-control flag at bit 20. All other bits read 0.
- R8: The command register is at address 4. Writing it with bit 0 set makes bit 0 read 1 until the update is applied. Writing it with bit 0 clear has no effect.
- R9: Writes to the configuration, M, N and D registers do not change the output sequence until an update is applied.
- R10: A pending update is applied in the clock edge that registers an output pulse of the running configuration. From that edge on, the request bit reads 0 and both counters restart from 0.
- R11: clk_en_o is registered. It is high in the cycle after the selected enable that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_en | input | NSRC | Per-source clock enables |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 cfg, 1 M, 2 N, 3 D, 4 command) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address, same map |
| rd_data | output | 32 | Combinational read data |
| clk_en_o | output | 1 | Generated clock enable pulse |
| duty_o | output | 1 | Duty-cycle level in fractional mode |

## Verification
The bench builds the block with NSRC = 4 and MND_W = 6. The narrow field width lets short write values show truncation of M, N and D. It also keeps the inverted encodings of N and D small enough to check by hand. With four sources, a select value of 7 lies outside the implemented range.

A reference model runs cycle by cycle on random enables on all sources. It covers bypass, integer and half-step pre-division, and two M/N/D settings, one of them chained behind a 1.5 pre-divider. It also places update requests where the selected source is idle, so the request stays pending across several cycles before the boundary arrives.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
   localparam int REG_W     = 32;
   localparam int ADDR_W    = 3;
   localparam int DIV_W     = 5;
   localparam int SRC_W     = 3;
   localparam int MODE_W    = 2;
   localparam int DIV_LSB   = 0;
   localparam int SRC_LSB   = 8;
   localparam int MODE_LSB  = 12;
   localparam int HWCTL_BIT = 20;
   localparam int MAX_SRC   = 1 << SRC_W;
   localparam logic [MODE_W-1:0] MODE_FRAC = 2'd2;

   typedef enum logic [ADDR_W-1:0] {
      A_CFG = 3'd0,
      A_MV  = 3'd1,
      A_NV  = 3'd2,
      A_DV  = 3'd3,
      A_CMD = 3'd4
   } rcg_addr_e;
endpackage

// File: rtl/rcg_regs.sv
module rcg_regs
   import rcg_pkg::*;
#(
   parameter int MND_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [REG_W-1:0]     wr_data,
   input  logic [ADDR_W-1:0]    rd_addr,
   input  logic                 boundary,
   output logic [REG_W-1:0]     rd_data,
   output logic [DIV_W-1:0]     act_div,
   output logic [SRC_W-1:0]     act_src,
   output logic [MODE_W-1:0]    act_mode,
   output logic [MND_W-1:0]     act_m,
   output logic [MND_W-1:0]     act_n,
   output logic [MND_W-1:0]     act_d,
   output logic                 pend,
   output logic                 apply
);
   logic [DIV_W-1:0]  sh_div;
   logic [SRC_W-1:0]  sh_src;
   logic [MODE_W-1:0] sh_mode;
   logic              sh_hw;
   logic [MND_W-1:0]  sh_m, sh_n, sh_d;
   logic              unused_wr;

   assign unused_wr = ^wr_data;
   assign apply     = pend & boundary;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_div <= '0; sh_src <= '0; sh_mode <= '0; sh_hw <= 1'b0;
         sh_m <= '0; sh_n <= '0; sh_d <= '0;
         act_div <= '0; act_src <= '0; act_mode <= '0;
         act_m <= '0; act_n <= '0; act_d <= '0;
         pend <= 1'b0;
      end else begin
         if (apply) begin
            act_div  <= sh_div;
            act_src  <= sh_src;
            act_mode <= sh_mode;
            act_m    <= sh_m;
            act_n    <= sh_n;
            act_d    <= sh_d;
            pend     <= 1'b0;
         end
         if (wr_en) begin
            case (wr_addr)
               A_CFG: begin
                  sh_div  <= wr_data[DIV_LSB +: DIV_W];
                  sh_src  <= wr_data[SRC_LSB +: SRC_W];
                  sh_mode <= wr_data[MODE_LSB +: MODE_W];
                  sh_hw   <= wr_data[HWCTL_BIT];
               end
               A_MV:  sh_m <= wr_data[MND_W-1:0];
               A_NV:  sh_n <= wr_data[MND_W-1:0];
               A_DV:  sh_d <= wr_data[MND_W-1:0];
               A_CMD: if (wr_data[0]) pend <= 1'b1;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_CFG: begin
            rd_data[DIV_LSB +: DIV_W]   = sh_div;
            rd_data[SRC_LSB +: SRC_W]   = sh_src;
            rd_data[MODE_LSB +: MODE_W] = sh_mode;
            rd_data[HWCTL_BIT]          = sh_hw;
         end
         A_MV:  rd_data[MND_W-1:0] = sh_m;
         A_NV:  rd_data[MND_W-1:0] = sh_n;
         A_DV:  rd_data[MND_W-1:0] = sh_d;
         A_CMD: rd_data[0]         = pend;
         default: ;
      endcase
   end
endmodule

// File: rtl/rcg_prediv.sv
module rcg_prediv
   import rcg_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en_in,
   input  logic [DIV_W-1:0] div,
   output logic             pulse
);
   localparam int CNT_W = DIV_W + 1;

   logic [CNT_W-1:0] cnt, cnt_nxt, sum, lim;

   assign sum = cnt + CNT_W'(2);
   assign lim = {1'b0, div} + CNT_W'(1);

   always_comb begin
      pulse   = 1'b0;
      cnt_nxt = cnt;
      if (div == '0) begin
         pulse = en_in;
      end else if (en_in) begin
         if (sum >= lim) begin
            pulse   = 1'b1;
            cnt_nxt = sum - lim;
         end else begin
            cnt_nxt = sum;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) cnt <= '0;
      else               cnt <= cnt_nxt;
   end
endmodule

// File: rtl/rcg_mnd.sv
module rcg_mnd #(
   parameter int MND_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en_in,
   input  logic             active,
   input  logic [MND_W-1:0] m_val,
   input  logic [MND_W-1:0] n_inv,
   input  logic [MND_W-1:0] d_inv,
   output logic             pulse,
   output logic             duty_nxt
);
   localparam int ACC_W = MND_W + 1;

   logic [MND_W-1:0] n_dec, d_dec;
   logic [ACC_W-1:0] acc, acc_nxt, sum;

   assign n_dec = (~n_inv) + m_val;
   assign d_dec = ~d_inv;
   assign sum   = acc + {1'b0, m_val};

   always_comb begin
      pulse    = en_in;
      acc_nxt  = '0;
      duty_nxt = 1'b0;
      if (active) begin
         pulse   = 1'b0;
         acc_nxt = acc;
         if (en_in) begin
            if (sum >= {1'b0, n_dec}) begin
               pulse   = 1'b1;
               acc_nxt = sum - {1'b0, n_dec};
            end else begin
               acc_nxt = sum;
            end
         end
         duty_nxt = (acc_nxt < {1'b0, d_dec});
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) acc <= '0;
      else               acc <= acc_nxt;
   end
endmodule

// File: rtl/clk_root_gen.sv
module clk_root_gen
   import rcg_pkg::*;
#(
   parameter int NSRC    = 8,
   parameter int MND_W   = 8,
   parameter bit USE_MND = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_en,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [2:0]        rd_addr,
   output logic [31:0]       rd_data,
   output logic              clk_en_o,
   output logic              duty_o
);
   if (NSRC < 1 || NSRC > MAX_SRC) begin : g_bad_nsrc
      $error("clk_root_gen: NSRC must lie in 1..8");
   end
   if (MND_W < 2 || MND_W > 16) begin : g_bad_mndw
      $error("clk_root_gen: MND_W must lie in 2..16");
   end

   logic [DIV_W-1:0]   act_div;
   logic [SRC_W-1:0]   act_src;
   logic [MODE_W-1:0]  act_mode;
   logic [MND_W-1:0]   act_m, act_n, act_d;
   logic               pend, apply;
   logic [MAX_SRC-1:0] src_pad;
   logic               sel_en, pd_pulse, out_pulse, duty_nxt, mnd_on;

   assign src_pad = MAX_SRC'(src_en);
   assign sel_en  = src_pad[act_src];
   assign mnd_on  = (act_mode == MODE_FRAC);

   rcg_regs #(.MND_W(MND_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .boundary(out_pulse), .rd_data(rd_data),
      .act_div(act_div), .act_src(act_src), .act_mode(act_mode),
      .act_m(act_m), .act_n(act_n), .act_d(act_d),
      .pend(pend), .apply(apply)
   );

   rcg_prediv u_prediv (
      .clk(clk), .rst_n(rst_n), .clr(apply),
      .en_in(sel_en), .div(act_div), .pulse(pd_pulse)
   );

   if (USE_MND) begin : g_frac
      rcg_mnd #(.MND_W(MND_W)) u_mnd (
         .clk(clk), .rst_n(rst_n), .clr(apply),
         .en_in(pd_pulse), .active(mnd_on),
         .m_val(act_m), .n_inv(act_n), .d_inv(act_d),
         .pulse(out_pulse), .duty_nxt(duty_nxt)
      );
   end else begin : g_nofrac
      assign out_pulse = pd_pulse;
      assign duty_nxt  = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         clk_en_o <= 1'b0;
         duty_o   <= 1'b0;
      end else begin
         clk_en_o <= out_pulse;
         duty_o   <= duty_nxt;
      end
   end
endmodule

// File: rtl/clk_root_gen_chk.sv
module clk_root_gen_chk
   import rcg_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              clk_en_o,
   input logic              duty_o,
   input logic              sel_en,
   input logic              pend,
   input logic              apply,
   input logic              mnd_on,
   input logic              wr_en,
   input logic [2:0]        wr_addr,
   input logic [31:0]       wr_data,
   input logic [DIV_W-1:0]  act_div,
   input logic [SRC_W-1:0]  act_src,
   input logic [MODE_W-1:0] act_mode
);
   // R11: an output pulse always follows a selected enable one cycle earlier
   p_pulse_after_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_o |-> $past(sel_en));

   // R10: the request clears only together with an output pulse
   p_apply_on_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend) |-> clk_en_o);

   // R8: a command write with bit 0 set leaves the request pending
   p_cmd_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 3'd4 && wr_data[0]) |=> pend);

   // R8: a command write with bit 0 clear does not raise the request
   p_cmd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 3'd4 && !wr_data[0] && !pend) |=> !pend);

   // R9: the running configuration moves only on an apply
   p_active_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !apply |=> ($stable(act_div) && $stable(act_src) && $stable(act_mode)));

   // R5: duty stays low outside fractional mode
   p_duty_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !mnd_on |=> !duty_o);
endmodule

bind clk_root_gen clk_root_gen_chk u_chk (
   .clk(clk), .rst_n(rst_n), .clk_en_o(clk_en_o), .duty_o(duty_o),
   .sel_en(sel_en), .pend(pend), .apply(apply), .mnd_on(mnd_on),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .act_div(act_div), .act_src(act_src), .act_mode(act_mode)
);

// File: tb/clk_root_gen_test.sv
module clk_root_gen_test;
   localparam int CLK_PERIOD = 20;
   localparam int NS = 4;
   localparam int W  = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src_en = '0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [2:0]    rd_addr = '0;
   logic [31:0]   rd_data;
   logic          clk_en_o, duty_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   clk_root_gen #(.NSRC(NS), .MND_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .src_en(src_en),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .clk_en_o(clk_en_o), .duty_o(duty_o)
   );

   int    vectors = 0;
   int    fails = 0;
   bit    need_edge = 0;
   string cur_tag = "R1";

   // reference model state, built from the requirements
   logic [4:0]   s_div = '0, a_div = '0;
   logic [2:0]   s_src = '0, a_src = '0;
   logic [1:0]   s_mode = '0, a_mode = '0;
   logic [W-1:0] s_m = '0, s_n = '0, s_d = '0;
   logic [W-1:0] a_m = '0, a_n = '0, a_d = '0;
   bit           pend = 0;
   int           pcnt = 0, acc = 0;

   logic [1:0] q_exp[$];
   string      q_tag[$];

   task automatic step(input logic [NS-1:0] s, input bit we,
                       input logic [2:0] wa, input logic [31:0] wd);
      logic sel, pd, pulse, duty;
      logic [W-1:0] nd, dd;
      int pn, an;
      bit on, app;
      @(negedge clk);
      src_en = s; wr_en = we; wr_addr = wa; wr_data = wd;
      need_edge = 1;
      sel = (int'(a_src) < NS) ? s[a_src] : 1'b0;
      pn = pcnt; pd = 1'b0;
      if (a_div == 0) pd = sel;
      else if (sel) begin
         if (pcnt + 2 >= int'(a_div) + 1) begin
            pd = 1'b1; pn = pcnt + 2 - int'(a_div) - 1;
         end else pn = pcnt + 2;
      end
      on = (a_mode == 2'd2);
      nd = ~a_n + a_m;
      dd = ~a_d;
      pulse = pd; duty = 1'b0; an = 0;
      if (on) begin
         pulse = 1'b0; an = acc;
         if (pd) begin
            if (acc + int'(a_m) >= int'(nd)) begin
               pulse = 1'b1; an = acc + int'(a_m) - int'(nd);
            end else an = acc + int'(a_m);
         end
         duty = (an < int'(dd));
      end
      q_exp.push_back({pulse, duty});
      q_tag.push_back(cur_tag);
      app = pend && pulse;
      if (app) begin
         a_div = s_div; a_src = s_src; a_mode = s_mode;
         a_m = s_m; a_n = s_n; a_d = s_d;
         pcnt = 0; acc = 0; pend = 0;
      end else begin
         pcnt = pn; acc = an;
      end
      if (we) begin
         case (wa)
            3'd0: begin s_div = wd[4:0]; s_src = wd[10:8]; s_mode = wd[13:12]; end
            3'd1: s_m = wd[W-1:0];
            3'd2: s_n = wd[W-1:0];
            3'd3: s_d = wd[W-1:0];
            3'd4: if (wd[0]) pend = 1;
            default: ;
         endcase
      end
   endtask

   task automatic burst(input int n, input logic [NS-1:0] mask);
      for (int i = 0; i < n; i++) begin
         logic [NS-1:0] r;
         r = NS'($urandom);
         step(r & mask, 1'b0, 3'd0, 32'd0);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      logic [NS-1:0] r;
      r = NS'($urandom);
      step(r, 1'b1, a, d);
   endtask

   task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
      if (need_edge) begin
         @(posedge clk); #2; need_edge = 0;
      end
      rd_addr = a;
      #1;
      vectors++;
      if (rd_data !== exp) begin
         fails++;
         $display("FAIL %s: read addr %0d actual=%h expected=%h", tag, a, rd_data, exp);
      end
   endtask

   // monitor: pops one expected item per clock edge after the stimulus
   always @(posedge clk) begin
      logic [1:0] e;
      string t;
      #1;
      if (q_exp.size() > 0) begin
         e = q_exp.pop_front();
         t = q_tag.pop_front();
         vectors++;
         if ({clk_en_o, duty_o} !== e) begin
            fails++;
            $display("FAIL %s: {clk_en_o,duty_o} actual=%b expected=%b at %0t",
                     t, {clk_en_o, duty_o}, e, $time);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R11: watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset contents and outputs
      for (int a = 0; a < 5; a++) rd_chk(3'(a), 32'd0, "R1");
      vectors++;
      if (clk_en_o !== 1'b0 || duty_o !== 1'b0) begin
         fails++;
         $display("FAIL R1: outputs actual=%b%b expected=00", clk_en_o, duty_o);
      end

      cur_tag = "R11"; burst(30, '1);

      // R2: move to source 2 while noise runs on the others
      cur_tag = "R2"; wr(3'd0, 32'h0000_0200); wr(3'd4, 32'd1); burst(40, '1);

      // R9: shadow write without update; R8: zero command write
      cur_tag = "R9"; wr(3'd0, 32'h0000_0203); burst(20, '1);
      cur_tag = "R8"; wr(3'd4, 32'd0); rd_chk(3'd4, 32'd0, "R8");

      // R8/R10: request held while the selected source is silent
      wr(3'd4, 32'd1); burst(6, 4'b1011);
      rd_chk(3'd4, 32'd1, "R8");
      cur_tag = "R10"; burst(40, '1);
      rd_chk(3'd4, {31'd0, pend}, "R10");

      // R3: half-step ratios 1.5, 2.5 and 1
      cur_tag = "R3";
      wr(3'd0, 32'h0000_0102); wr(3'd4, 32'd1); burst(40, '1);
      wr(3'd0, 32'h0000_0304); wr(3'd4, 32'd1); burst(40, '1);
      wr(3'd0, 32'h0000_0001); wr(3'd4, 32'd1); burst(30, '1);

      // R4: M=1 N=4 D=2, then M=3 N=8 D=3 behind a 1.5 pre-divider
      cur_tag = "R4";
      wr(3'd1, 32'd1); wr(3'd2, 32'd60); wr(3'd3, 32'd61);
      wr(3'd0, 32'h0000_2000); wr(3'd4, 32'd1); burst(60, '1);
      for (int i = 0; i < 20; i++) step('1, 1'b0, 3'd0, 32'd0);
      wr(3'd1, 32'd3); wr(3'd2, 32'd58); wr(3'd3, 32'd60);
      wr(3'd0, 32'h0000_2002); wr(3'd4, 32'd1); burst(80, '1);

      // R5: mode 3 keeps duty low
      cur_tag = "R5"; wr(3'd0, 32'h0000_3000); wr(3'd4, 32'd1); burst(40, '1);

      // R6: truncation of M, N, D
      cur_tag = "R6";
      wr(3'd1, 32'hFFFF_FFC5); rd_chk(3'd1, 32'h05, "R6");
      wr(3'd2, 32'h0000_1234); rd_chk(3'd2, 32'h34, "R6");
      wr(3'd3, 32'hABCD_EF7F); rd_chk(3'd3, 32'h3F, "R6");

      // R7: implemented configuration bits only
      cur_tag = "R7"; wr(3'd0, 32'hFFFF_FFFF); rd_chk(3'd0, 32'h0010_371F, "R7");
      burst(10, '1);
      step('0, 1'b0, 3'd0, 32'd0);

      repeat (3) @(posedge clk);
      #3;
      vectors++;
      if (q_exp.size() != 0) begin
         fails++;
         $display("FAIL R11: pending expected items actual=%0d expected=0", q_exp.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule